// File: doc/BRIEF.md
# Power-of-Two Period Watchdog Timer

This peripheral guards a system against software that stops servicing it. Software chooses a timeout by writing a 4-bit log2-coded period, picks where an expiry goes, and starts the timer with one control write that sets enable and clear together. After that, software services the timer from time to time with further clear writes. Each clear reloads the countdown. A read-only status bit shows that the reload has happened and that the counter is running.

The countdown steps once per pulse on `tick_i`, which is a one-second strobe made outside the block. The timeout is 2^(code-3) ticks, so code 3 gives 1 tick and code 10 gives 128 ticks. When the countdown reaches zero, the block raises an interrupt. Depending on the selection field, it also raises a reset request. Both stay raised until software clears or disables the timer. Writing enable as 0 stops the timer and drops the status bit, so software can wait for status 0 before it programs a new period.

The register port is a single-cycle write strobe with a combinational read of the addressed register. Only the low nibble of the address is decoded.

Top module: `pow2_wdt`

## Requirements
- R1: After reset, enable reads 0, status reads 0, the period code reads 3, the selection field reads 0, and `irq_o` and `rst_req_o` are low.
- R2: The period register is at offset 0x4, with the code in bits [3:0]. A written code below 3 is stored as 3, a code above 10 is stored as 10, and codes 3 to 10 are stored as written. The stored code reads back.
- R3: The selection register is at offset 0x8, in bits [1:0]. A value of 0 routes expiry to both `irq_o` and `rst_req_o`. Any nonzero value routes expiry to `irq_o` only. `rst_req_o` is never high while `irq_o` is low.
- R4: The control register is at offset 0xC. Bit 0 is enable and reads back as written. Bit 1 is clear and always reads 0. Bit 8 is status and is read-only.
- R5: A control write with bit 0 = 1 and bit 1 = 1 reloads the countdown with 2^(code-3) ticks and drops both outputs. Status reads 1 from the next cycle on.
- R6: Once the timer is running, `irq_o` stays low through the first 2^(code-3)-1 tick pulses. It is high in the cycle after the edge that samples the 2^(code-3)-th tick pulse.
- R7: Once raised, the expiry outputs stay high, and further ticks change nothing, until a clear write or a disable write.
- R8: A control write with bit 0 = 0 stops the timer. From the next cycle, status reads 0, both outputs are low, and ticks have no effect.
- R9: A control write that sets enable without setting clear does not start the countdown. Status stays 0 and no tick makes the block expire.
- R10: A period written while the timer runs does not change the countdown in progress. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register offset (low nibble) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the register at `addr_i`, combinational |
| tick_i | input | 1 | One-cycle pulse per second of timeout |
| irq_o | output | 1 | Expiry interrupt |
| rst_req_o | output | 1 | Expiry reset request |

## Verification
The assertions assume the following about the inputs:
- `tick_i` is a single-cycle strobe.
- A write lasts exactly one cycle.
- `addr_i` selects which register a write touches, so only writes to offset 0xC can start, clear or stop the countdown.

The stimulus keeps within these assumptions. Every write and tick is driven as a one-cycle pulse on the falling clock edge, and ticks never coincide with control writes. The sweep covers every period code, both kinds of routing, and each of the out-of-range codes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CODE_MIN = 3;
  localparam int unsigned CODE_MAX = 10;
  localparam int unsigned CNT_W    = CODE_MAX - CODE_MIN + 1;

  localparam logic [3:0] OFS_PERIOD = 4'h4;
  localparam logic [3:0] OFS_SEL    = 4'h8;
  localparam logic [3:0] OFS_CTRL   = 4'hC;

  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_CLR    = 1;
  localparam int unsigned BIT_STATUS = 8;

  typedef struct packed {
    logic kick;  // enable with clear: reload and run
    logic halt;  // enable written 0
  } wdt_cmd_t;

  function automatic logic [3:0] clamp_code(input logic [3:0] c);
    if (c < 4'(CODE_MIN))      return 4'(CODE_MIN);
    else if (c > 4'(CODE_MAX)) return 4'(CODE_MAX);
    else                       return c;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [3:0]        code_o,
  output logic [1:0]        sel_o,
  output wdt_cmd_t          cmd_o
);
  logic [3:0] code_q;
  logic [1:0] sel_q;
  logic       en_q;
  logic       ctrl_wr;

  assign ctrl_wr = wr_en_i && (addr_i == OFS_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= 4'(CODE_MIN);
      sel_q  <= '0;
      en_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFS_PERIOD: code_q <= clamp_code(wdata_i[3:0]);
        OFS_SEL:    sel_q  <= wdata_i[1:0];
        OFS_CTRL:   en_q   <= wdata_i[BIT_EN];
        default:    ;
      endcase
    end
  end

  always_comb begin
    cmd_o.kick = ctrl_wr && wdata_i[BIT_EN] && wdata_i[BIT_CLR];
    cmd_o.halt = ctrl_wr && !wdata_i[BIT_EN];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_PERIOD: rdata_o[3:0] = code_q;
      OFS_SEL:    rdata_o[1:0] = sel_q;
      OFS_CTRL: begin
        rdata_o[BIT_EN]     = en_q;
        rdata_o[BIT_STATUS] = status_i;
      end
      default: ;
    endcase
  end

  assign code_o = code_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  wdt_cmd_t     cmd_i,
  input  logic [3:0]   code_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         running_o,
  output logic         expired_o
);
  logic [W-1:0] cnt_q, load;
  logic         run_q, exp_q;

  assign load = W'(1) << (code_i - 4'(CODE_MIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (cmd_i.halt) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (cmd_i.kick) begin
      cnt_q <= load;
      run_q <= 1'b1;
      exp_q <= 1'b0;
    end else if (run_q && !exp_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == W'(1)) exp_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = run_q;
  assign expired_o = exp_q;
endmodule

// File: rtl/wdt_route.sv
module wdt_route (
  input  logic       expired_i,
  input  logic [1:0] sel_i,
  output logic       irq_o,
  output logic       rst_req_o
);
  assign irq_o     = expired_i;
  assign rst_req_o = expired_i && (sel_i == 2'd0);
endmodule

// File: rtl/pow2_wdt.sv
module pow2_wdt
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        tick_i,
  output logic        irq_o,
  output logic        rst_req_o
);
  wdt_cmd_t         cmd;
  logic [3:0]       code;
  logic [1:0]       sel;
  logic [CNT_W-1:0] cnt;
  logic             running, expired;

  wdt_regs #(.DATA_W(32)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .status_i(running), .rdata_o, .code_o(code), .sel_o(sel), .cmd_o(cmd)
  );

  wdt_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .cmd_i(cmd), .code_i(code), .tick_i,
    .cnt_o(cnt), .running_o(running), .expired_o(expired)
  );

  wdt_route u_route (
    .expired_i(expired), .sel_i(sel), .irq_o, .rst_req_o
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [3:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             tick_i,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic [3:0]       code,
  input logic [CNT_W-1:0] cnt,
  input logic             running
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (addr_i == OFS_CTRL);

  // R3
  rst_needs_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> irq_o);

  // R8
  halt_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wdata_i[0]) |=> (!running && !irq_o && !rst_req_o));

  // R5
  kick_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[0] && wdata_i[1]) |=> (running && !irq_o));

  // R7
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ctrl_wr) |=> irq_o);

  // R6
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ctrl_wr) |=> $stable(cnt));

  // R2
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code >= 4'(CODE_MIN)) && (code <= 4'(CODE_MAX)));

  // R4
  clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_CTRL) |-> !rdata_o[1]);

  // R9
  start_needs_kick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !(ctrl_wr && wdata_i[0] && wdata_i[1])) |=> !running);
endmodule

bind pow2_wdt wdt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i), .irq_o(irq_o),
  .rst_req_o(rst_req_o), .code(code), .cnt(cnt), .running(running)
);

// File: tb/tb_pow2_wdt.sv
module tb_pow2_wdt;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, tick = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, rst_req;
  int total = 0, bad = 0;

  pow2_wdt dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .irq_o(irq),
    .rst_req_o(rst_req)
  );

  always #2 clk = ~clk;

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog: run hung, act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  logic [31:0] r;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(4'hC, r); chk("R1 ctrl", r, 0);
    rd(4'h4, r); chk("R1 period", r, 3);
    rd(4'h8, r); chk("R1 sel", r, 0);
    chk("R1 irq", irq, 0); chk("R1 rst", rst_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 clamp sweep
    for (int c = 0; c < 16; c++) begin
      wr(4'h4, 32'(c));
      rd(4'h4, r);
      chk("R2 code", r, (c < 3) ? 3 : (c > 10) ? 10 : c);
    end

    // R3 selection sweep on 1-tick period
    wr(4'h4, 3);
    for (int s = 0; s < 4; s++) begin
      wr(4'h8, 32'(s));
      rd(4'h8, r); chk("R3 sel rb", r, s);
      wr(4'hC, 3);
      ticks(1);
      chk("R3 irq", irq, 1);
      chk("R3 rst", rst_req, (s == 0) ? 1 : 0);
      wr(4'hC, 0);
    end

    // R6 expiry timing for every code, both routings
    for (int c = 3; c <= 10; c++) begin
      for (int k = 0; k < 2; k++) begin
        int n;
        n = 1 << (c - 3);
        wr(4'h8, k * 2);
        wr(4'h4, 32'(c));
        wr(4'hC, 3);
        rd(4'hC, r);
        chk("R5 status", r[8], 1);
        chk("R4 clr rd", r[1], 0);
        chk("R4 en rd", r[0], 1);
        ticks(n - 1);
        chk("R6 early", irq, 0);
        ticks(1);
        chk("R6 irq", irq, 1);
        chk("R3 route", rst_req, (k == 0) ? 1 : 0);
        wr(4'hC, 0);
        rd(4'hC, r);
        chk("R8 status", r[8], 0);
        chk("R8 irq", irq, 0);
      end
    end

    // R7 sticky then cleared
    wr(4'h8, 0); wr(4'h4, 4);
    wr(4'hC, 3); ticks(2);
    chk("R7 irq", irq, 1);
    ticks(5);
    chk("R7 hold irq", irq, 1); chk("R7 hold rst", rst_req, 1);
    wr(4'hC, 3);
    chk("R5 clr drops", irq, 0);
    ticks(1); chk("R5 reload", irq, 0);
    ticks(1); chk("R5 reexp", irq, 1);

    // R8 stopped timer never fires
    wr(4'hC, 3); ticks(1);
    wr(4'hC, 0);
    ticks(6);
    chk("R8 no fire", irq, 0);
    rd(4'hC, r); chk("R8 stat0", r[8], 0);

    // R9 enable alone does not start
    wr(4'h4, 3);
    wr(4'hC, 1);
    rd(4'hC, r); chk("R9 en", r[0], 1); chk("R9 stat", r[8], 0);
    ticks(3);
    chk("R9 no fire", irq, 0);

    // R10 period change mid-run applies at next reload
    wr(4'hC, 0);
    wr(4'h4, 3); wr(4'hC, 3);
    wr(4'h4, 5);
    ticks(1);
    chk("R10 old period", irq, 1);
    wr(4'hC, 3);
    ticks(3); chk("R10 new early", irq, 0);
    ticks(1); chk("R10 new exp", irq, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule